// File: doc/BRIEF.md
# Thermal Protection Status Controller

The controller turns a digitized junction-temperature reading into one of four protection levels: normal, warning, bridge shutdown and device shutdown. Each level above normal has its own set threshold and its own lower release threshold, so each level has its own hysteresis band. The present level is re-evaluated only when a sample strobe arrives. One sample may move the level up or down by more than one step.

The level is reported as a 2-bit code. It also drives a graded set of shutdown requests. A warning restricts nothing. Bridge shutdown disables the gate drivers. Device shutdown also disables the main supply regulator, asks the auxiliary regulator to limit its current, and stops the charge pump. Software or a wrapper loads the six thresholds. They must satisfy release < set for each level and warning < bridge < device.

Top module: `thermal_guard`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and on the first cycle after it, `status` is 2'b00 and all four disable outputs are low.
- R2: Status codes are 2'b00 normal, 2'b01 warning, 2'b10 bridge shutdown and 2'b11 device shutdown. In normal and in warning, all four disable outputs are low.
- R3: In bridge shutdown (2'b10), `gate_drv_off` is high and `main_reg_off`, `aux_reg_ilim` and `pump_off` are low.
- R4: In device shutdown (2'b11), `gate_drv_off`, `main_reg_off`, `aux_reg_ilim` and `pump_off` are all high.
- R5: When `sample_vld` is low, `status` keeps its value whatever `temp_sample` and the thresholds do.
- R6: A level is entered only when the sample is strictly greater than that level's set threshold. A sample equal to the set threshold does not enter the level.
- R7: An active level is left only when the sample is strictly below its release threshold. A sample equal to the release threshold keeps the level.
- R8: One valid sample can raise the status by several levels (normal straight to device shutdown) or lower it by several levels (device shutdown straight to normal).
- R9: The next status is the highest level whose condition holds. A level's condition holds if the sample is above its set threshold, or if the level is at or below the current status and the sample is not below its release threshold.
- R10: A sample taken with `sample_vld` high at a rising clock edge sets `status` at that same edge. With `ACT_REG`=0 the disable outputs follow `status` in the same cycle. With `ACT_REG`=1 they follow one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | Temperature sample strobe |
| temp_sample | input | TEMP_W | Junction temperature sample (unsigned) |
| warn_set | input | TEMP_W | Warning set threshold |
| warn_rel | input | TEMP_W | Warning release threshold |
| brg_set | input | TEMP_W | Bridge-shutdown set threshold |
| brg_rel | input | TEMP_W | Bridge-shutdown release threshold |
| dev_set | input | TEMP_W | Device-shutdown set threshold |
| dev_rel | input | TEMP_W | Device-shutdown release threshold |
| status | output | 2 | Protection level code |
| gate_drv_off | output | 1 | Gate-driver disable |
| main_reg_off | output | 1 | Main supply regulator disable |
| aux_reg_ilim | output | 1 | Auxiliary regulator current-limit request |
| pump_off | output | 1 | Charge-pump disable |

## Verification
The bench builds the block with `TEMP_W`=8 and `ACT_REG`=0. The 8-bit width lets the six thresholds sit at hand-picked values with ten-count bands. Samples can therefore land exactly on a set or release threshold, one count either side of it, or inside a band. With combinational actions, every output check falls in the cycle right after the strobe edge. That makes the multi-level jumps and the release-to-highest-holding-level cases directly visible at the ports.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;

   typedef enum logic [1:0] {
      TG_NORMAL = 2'b00,
      TG_WARN   = 2'b01,
      TG_BRIDGE = 2'b10,
      TG_DEVICE = 2'b11
   } tg_level_e;

   localparam int TG_NUM_TRIP = 3;

   typedef struct packed {
      logic gate_off;
      logic main_off;
      logic aux_ilim;
      logic pump_off;
   } tg_action_t;

endpackage

// File: rtl/tg_trip_cell.sv
module tg_trip_cell #(
   parameter int TEMP_W = 10,
   parameter int LEVEL  = 1
) (
   input  logic [TEMP_W-1:0] temp,
   input  logic [TEMP_W-1:0] set_thr,
   input  logic [TEMP_W-1:0] rel_thr,
   input  logic [1:0]        cur_level,
   output logic              hold
);
   localparam logic [1:0] LVL_CODE = 2'(LEVEL);

   logic engaged;
   logic above_set;
   logic not_released;

   assign engaged      = (cur_level >= LVL_CODE);
   assign above_set    = (temp > set_thr);
   assign not_released = (temp >= rel_thr);
   assign hold         = above_set | (engaged & not_released);
endmodule

// File: rtl/tg_level_select.sv
module tg_level_select
   import thermal_guard_pkg::*;
(
   input  logic [TG_NUM_TRIP-1:0] hold,
   output tg_level_e              next_level
);
   always_comb begin
      if (hold[2])      next_level = TG_DEVICE;
      else if (hold[1]) next_level = TG_BRIDGE;
      else if (hold[0]) next_level = TG_WARN;
      else              next_level = TG_NORMAL;
   end
endmodule

// File: rtl/tg_action_map.sv
module tg_action_map
   import thermal_guard_pkg::*;
#(
   parameter int ACT_REG = 0
) (
   input  logic       clk,
   input  logic       rst,
   input  tg_level_e  level,
   output tg_action_t act
);
   tg_action_t act_c;

   always_comb begin
      act_c          = '0;
      act_c.gate_off = (level == TG_BRIDGE) || (level == TG_DEVICE);
      act_c.main_off = (level == TG_DEVICE);
      act_c.aux_ilim = (level == TG_DEVICE);
      act_c.pump_off = (level == TG_DEVICE);
   end

   generate
      if (ACT_REG != 0) begin : g_reg
         tg_action_t act_q;
         always_ff @(posedge clk) begin
            if (rst) act_q <= '0;
            else     act_q <= act_c;
         end
         assign act = act_q;
      end else begin : g_comb
         assign act = act_c;
      end
   endgenerate
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
   import thermal_guard_pkg::*;
#(
   parameter int TEMP_W  = 10,
   parameter int ACT_REG = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sample_vld,
   input  logic [TEMP_W-1:0] temp_sample,
   input  logic [TEMP_W-1:0] warn_set,
   input  logic [TEMP_W-1:0] warn_rel,
   input  logic [TEMP_W-1:0] brg_set,
   input  logic [TEMP_W-1:0] brg_rel,
   input  logic [TEMP_W-1:0] dev_set,
   input  logic [TEMP_W-1:0] dev_rel,
   output logic [1:0]        status,
   output logic              gate_drv_off,
   output logic              main_reg_off,
   output logic              aux_reg_ilim,
   output logic              pump_off
);
   generate
      if (TEMP_W < 2 || TEMP_W > 32) begin : g_bad_width
         $error("thermal_guard: TEMP_W must be within 2..32");
      end
      if (ACT_REG != 0 && ACT_REG != 1) begin : g_bad_actreg
         $error("thermal_guard: ACT_REG must be 0 or 1");
      end
   endgenerate

   tg_level_e                lvl_q;
   tg_level_e                lvl_nxt;
   logic [TG_NUM_TRIP-1:0]   hold;
   logic [TEMP_W-1:0]        set_arr [TG_NUM_TRIP];
   logic [TEMP_W-1:0]        rel_arr [TG_NUM_TRIP];
   tg_action_t               act;

   assign set_arr[0] = warn_set;
   assign set_arr[1] = brg_set;
   assign set_arr[2] = dev_set;
   assign rel_arr[0] = warn_rel;
   assign rel_arr[1] = brg_rel;
   assign rel_arr[2] = dev_rel;

   generate
      for (genvar i = 0; i < TG_NUM_TRIP; i++) begin : g_trip
         tg_trip_cell #(
            .TEMP_W (TEMP_W),
            .LEVEL  (i + 1)
         ) u_cell (
            .temp      (temp_sample),
            .set_thr   (set_arr[i]),
            .rel_thr   (rel_arr[i]),
            .cur_level (lvl_q),
            .hold      (hold[i])
         );
      end
   endgenerate

   tg_level_select u_sel (
      .hold       (hold),
      .next_level (lvl_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst)             lvl_q <= TG_NORMAL;
      else if (sample_vld) lvl_q <= lvl_nxt;
   end

   tg_action_map #(
      .ACT_REG (ACT_REG)
   ) u_act (
      .clk   (clk),
      .rst   (rst),
      .level (lvl_q),
      .act   (act)
   );

   assign status       = lvl_q;
   assign gate_drv_off = act.gate_off;
   assign main_reg_off = act.main_off;
   assign aux_reg_ilim = act.aux_ilim;
   assign pump_off     = act.pump_off;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
   parameter int TEMP_W  = 10,
   parameter int ACT_REG = 0
) (
   input logic              clk,
   input logic              rst,
   input logic              sample_vld,
   input logic [TEMP_W-1:0] temp_sample,
   input logic [TEMP_W-1:0] warn_set,
   input logic [TEMP_W-1:0] dev_rel,
   input logic [1:0]        status,
   input logic              gate_drv_off,
   input logic              main_reg_off,
   input logic              aux_reg_ilim,
   input logic              pump_off
);
   logic [1:0] prev_status;
   logic [1:0] act_src;

   always_ff @(posedge clk) begin
      if (rst) prev_status <= 2'b00;
      else     prev_status <= status;
   end

   assign act_src = (ACT_REG != 0) ? prev_status : status;

   // R1
   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (status == 2'b00 && !gate_drv_off && !main_reg_off && !aux_reg_ilim && !pump_off));

   // R2
   a_r2_low_levels_quiet: assert property (@(posedge clk) disable iff (rst)
      (act_src < 2'd2) |-> (!gate_drv_off && !main_reg_off && !aux_reg_ilim && !pump_off));

   // R3
   a_r3_bridge_gate_only: assert property (@(posedge clk) disable iff (rst)
      (act_src == 2'd2) |-> (gate_drv_off && !main_reg_off && !aux_reg_ilim && !pump_off));

   // R4
   a_r4_device_all_off: assert property (@(posedge clk) disable iff (rst)
      (act_src == 2'd3) |-> (gate_drv_off && main_reg_off && aux_reg_ilim && pump_off));

   // R5
   a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
      !sample_vld |=> $stable(status));

   // R6
   a_r6_no_entry_at_or_below_set: assert property (@(posedge clk) disable iff (rst)
      (sample_vld && status == 2'b00 && temp_sample <= warn_set) |=> (status == 2'b00));

   // R7
   a_r7_device_kept_at_release: assert property (@(posedge clk) disable iff (rst)
      (sample_vld && status == 2'b11 && temp_sample >= dev_rel) |=> (status == 2'b11));
endmodule

bind thermal_guard tg_checker #(
   .TEMP_W  (TEMP_W),
   .ACT_REG (ACT_REG)
) u_tg_checker (
   .clk          (clk),
   .rst          (rst),
   .sample_vld   (sample_vld),
   .temp_sample  (temp_sample),
   .warn_set     (warn_set),
   .dev_rel      (dev_rel),
   .status       (status),
   .gate_drv_off (gate_drv_off),
   .main_reg_off (main_reg_off),
   .aux_reg_ilim (aux_reg_ilim),
   .pump_off     (pump_off)
);

// File: tb/test_thermal_guard.sv
`timescale 1ns/1ps
module test_thermal_guard;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sample_vld = 1'b0;
   logic [TW-1:0] temp_sample = '0;
   logic [TW-1:0] warn_set = 8'd100, warn_rel = 8'd90;
   logic [TW-1:0] brg_set  = 8'd130, brg_rel  = 8'd120;
   logic [TW-1:0] dev_set  = 8'd160, dev_rel  = 8'd150;
   logic [1:0]    status;
   logic          gate_drv_off, main_reg_off, aux_reg_ilim, pump_off;

   int total = 0;
   int bad   = 0;
   logic [1:0] model = 2'b00;

   always #5 clk = ~clk;

   thermal_guard #(.TEMP_W(TW), .ACT_REG(0)) i_thermal_guard (
      .clk(clk), .rst(rst), .sample_vld(sample_vld), .temp_sample(temp_sample),
      .warn_set(warn_set), .warn_rel(warn_rel), .brg_set(brg_set), .brg_rel(brg_rel),
      .dev_set(dev_set), .dev_rel(dev_rel), .status(status),
      .gate_drv_off(gate_drv_off), .main_reg_off(main_reg_off),
      .aux_reg_ilim(aux_reg_ilim), .pump_off(pump_off));

   // Spec model of R9 with strict set (R6) and strict release (R7)
   function automatic logic [1:0] spec_next(input logic [1:0] cur, input logic [TW-1:0] t);
      logic h3, h2, h1;
      h3 = (t > dev_set)  || (cur >= 2'd3 && !(t < dev_rel));
      h2 = (t > brg_set)  || (cur >= 2'd2 && !(t < brg_rel));
      h1 = (t > warn_set) || (cur >= 2'd1 && !(t < warn_rel));
      if (h3)      return 2'd3;
      else if (h2) return 2'd2;
      else if (h1) return 2'd1;
      else         return 2'd0;
   endfunction

   task automatic check_all(input logic [1:0] exp, input string tag);
      logic [3:0] exp_act, got_act;
      exp_act = {exp >= 2'd2, exp == 2'd3, exp == 2'd3, exp == 2'd3};
      got_act = {gate_drv_off, main_reg_off, aux_reg_ilim, pump_off};
      total++;
      if (status !== exp) begin
         bad++;
         $display("FAIL %s status: actual=%b expected=%b", tag, status, exp);
      end
      total++;
      if (got_act !== exp_act) begin
         bad++;
         $display("FAIL %s actions: actual=%b expected=%b", tag, got_act, exp_act);
      end
   endtask

   // One strobed sample; outputs checked at the following negedge (R10)
   task automatic apply(input logic [TW-1:0] t, input logic [1:0] exp, input string tag);
      @(negedge clk);
      temp_sample = t;
      sample_vld  = 1'b1;
      model       = spec_next(model, t);
      @(negedge clk);
      sample_vld  = 1'b0;
      if (model !== exp) $display("note: bench table mismatch at %s", tag);
      check_all(exp, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check_all(2'b00, "R1 during reset");
      rst = 1'b0;
      model = 2'b00;
      @(negedge clk);
      check_all(2'b00, "R1 after reset");
   endtask

   task automatic t_r2_warning();
      apply(8'd101, 2'b01, "R2 warning entered");
      apply(8'd95,  2'b01, "R2 warning held in band");
      apply(8'd89,  2'b00, "R2 normal after release");
   endtask

   task automatic t_r6_r7_edges();
      apply(8'd100, 2'b00, "R6 equal to warn set stays normal");
      apply(8'd101, 2'b01, "R6 one above warn set");
      apply(8'd90,  2'b01, "R7 equal to warn release holds");
      apply(8'd89,  2'b00, "R7 one below warn release");
      apply(8'd130, 2'b01, "R6 equal to bridge set");
   endtask

   task automatic t_r3_bridge();
      apply(8'd131, 2'b10, "R3 bridge entered");
      apply(8'd120, 2'b10, "R3 bridge held at release");
      apply(8'd119, 2'b01, "R9 bridge release lands in warning");
   endtask

   task automatic t_r4_device();
      apply(8'd161, 2'b11, "R4 device entered");
      apply(8'd150, 2'b11, "R7 device held at release");
      apply(8'd149, 2'b10, "R9 device release lands in bridge");
      apply(8'd89,  2'b00, "R8 bridge straight to normal");
   endtask

   task automatic t_r8_jumps();
      apply(8'd200, 2'b11, "R8 normal straight to device");
      apply(8'd95,  2'b01, "R9 device release lands in warning");
      apply(8'd170, 2'b11, "R8 warning straight to device");
      apply(8'd10,  2'b00, "R8 device straight to normal");
   endtask

   task automatic t_r5_no_strobe();
      @(negedge clk);
      temp_sample = 8'd250;
      repeat (4) @(negedge clk);
      check_all(2'b00, "R5 hot sample without strobe ignored");
      apply(8'd135, 2'b10, "R5 setup bridge");
      @(negedge clk);
      temp_sample = 8'd5;
      repeat (3) @(negedge clk);
      check_all(2'b10, "R5 cold sample without strobe ignored");
   endtask

   task automatic t_r1_reset_from_device();
      apply(8'd180, 2'b11, "R1 setup device");
      do_reset();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      do_reset();
      t_r2_warning();
      t_r6_r7_edges();
      t_r3_bridge();
      t_r4_device();
      t_r8_jumps();
      t_r5_no_strobe();
      t_r1_reset_from_device();
      apply(8'd120, 2'b01, "R10 single strobe updates status");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule